// File: doc/BRIEF.md
# Linear Address Masking Unit

This unit sits on the data address path of a 64-bit core. Software can keep metadata in the upper bits of a pointer, and this unit removes those bits before translation. Each beat carries a 64-bit linear address and a valid strobe. The core also supplies two user-side masking enables, a supervisor-side masking enable, a flag for 5-level paging, and a flag that marks the access as an instruction fetch. From these inputs the unit picks a masking width for that pointer. It replaces the metadata bits with copies of the highest usable address bit. It then checks that what remains is canonical.

The pointer's bit 63 alone decides whether the user or the supervisor controls apply. Privilege level plays no part. Instruction fetches are never masked and go through the plain canonical check. The untagged address and a fault flag come out one clock later, together with an output valid flag. When the check fails, the reported address has its metadata cleared and is in canonical form, so a fault handler can record it as it stands.

The unit has no sequencing of its own. It has three named masking modes: NONE (no masking), W48 (bits 62:48 are metadata) and W57 (bits 62:57 are metadata). A new mode is chosen for every beat, and there are no transitions that depend on an earlier beat.

Top module: `addr_untag_unit`

## Requirements
- R1: During and directly after reset, out_valid, out_fault and out_addr are all zero.
- R2: out_valid repeats in_valid one clock later. A cycle with in_valid low gives out_valid low and out_fault low on the next clock.
- R3: For a data pointer with bit 63 = 0, user_mask57 = 1 selects W57 whatever user_mask48 is. user_mask48 = 1 with user_mask57 = 0 selects W48. Both low selects NONE. sup_mask_en has no effect.
- R4: For a data pointer with bit 63 = 1 and sup_mask_en = 1, W48 is selected under 4-level paging (paging5 = 0) and W57 under 5-level paging. sup_mask_en = 0 selects NONE. The user enables have no effect.
- R5: In W48 the output has bits 62:48 equal to input bit 47, and bits 63 and 47:0 unchanged.
- R6: In W57 the output has bits 62:57 equal to input bit 56, and bits 63 and 56:0 unchanged.
- R7: In W48 out_fault is 1 exactly when input bit 63 differs from bit 47. In W57 it is 1 exactly when bit 63 differs from bit 56.
- R8: In NONE, out_fault is 1 unless input bits 63:47 are all equal (4-level) or bits 63:56 are all equal (5-level). A NONE beat without a fault outputs the input address unchanged.
- R9: A beat with is_fetch = 1 is handled as NONE whatever the masking enables are.
- R10: Under 5-level paging, a user pointer in W48 is treated as 48 bits wide: bits 56:48 are cleared as metadata, and the check uses bit 47.
- R11: On a fault, out_addr keeps the input bits below the top usable bit (bit 47 for width 48, bit 56 for width 57), including that bit. Every bit above it, bit 63 included, is set to a copy of that bit. The result is canonical, with its metadata cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Address beat valid |
| in_addr | input | 64 | Linear address, possibly tagged |
| user_mask48 | input | 1 | User pointers: 48-bit masking enable |
| user_mask57 | input | 1 | User pointers: 57-bit masking enable (wins over 48) |
| sup_mask_en | input | 1 | Supervisor pointers: masking enable |
| paging5 | input | 1 | 1 = 5-level paging, 0 = 4-level |
| is_fetch | input | 1 | 1 = instruction fetch (never masked) |
| out_valid | output | 1 | Result valid, one clock after in_valid |
| out_addr | output | 64 | Untagged address, or canonical fault address |
| out_fault | output | 1 | Non-canonical fault |

## Verification
The assertions assume that the control inputs and the address are stable across the clock edge that captures a beat. They also assume that in_valid is held low for the whole of reset, because the pipeline checks compare against the previous cycle. The bench changes every input only on the falling clock edge and keeps in_valid low until reset has been released. As a result, each $past term refers to a beat that was actually presented after reset.

// File: rtl/addr_untag_pkg.sv
package addr_untag_pkg;
    typedef enum logic [1:0] {
        MODE_NONE = 2'd0,
        MODE_W48  = 2'd1,
        MODE_W57  = 2'd2
    } mask_mode_e;
endpackage

// File: rtl/addr_mode_sel.sv
module addr_mode_sel
    import addr_untag_pkg::*;
(
    input  logic       ptr_sup,
    input  logic       is_fetch,
    input  logic       user_mask48,
    input  logic       user_mask57,
    input  logic       sup_mask_en,
    input  logic       paging5,
    output mask_mode_e mode
);
    logic [1:0] sel;

    always_comb begin
        sel = {is_fetch, ptr_sup};
        mode = MODE_NONE;
        unique case (sel)
            2'b00: begin
                if (user_mask57)      mode = MODE_W57;
                else if (user_mask48) mode = MODE_W48;
                else                  mode = MODE_NONE;
            end
            2'b01: begin
                if (sup_mask_en) mode = paging5 ? MODE_W57 : MODE_W48;
                else             mode = MODE_NONE;
            end
            default: mode = MODE_NONE;
        endcase
    end

    always_comb begin
        if (is_fetch) begin
            AST_FETCH_UNMASKED: assert (mode == MODE_NONE); // R9
        end
    end
endmodule

// File: rtl/addr_strip_check.sv
module addr_strip_check
    import addr_untag_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int NARROW_W = 48,
    parameter int WIDE_W   = 57
) (
    input  logic [ADDR_W-1:0] addr,
    input  mask_mode_e        mode,
    input  logic              paging5,
    output logic [ADDR_W-1:0] result,
    output logic              fault
);
    localparam int SIGN_BIT = ADDR_W - 1;
    localparam int TOP_N    = NARROW_W - 1;
    localparam int TOP_W    = WIDE_W - 1;

    int          top;
    logic        masked;
    logic [ADDR_W-1:0] stripped;
    logic [ADDR_W-1:0] canon;
    logic        upper_same;

    always_comb begin
        unique case (mode)
            MODE_W48: top = TOP_N;
            MODE_W57: top = TOP_W;
            default:  top = paging5 ? TOP_W : TOP_N;
        endcase
        masked = (mode != MODE_NONE);

        stripped   = addr;
        canon      = addr;
        upper_same = 1'b1;
        for (int i = 0; i < ADDR_W; i++) begin
            if (i > top) begin
                canon[i] = addr[top];
                if (addr[i] != addr[SIGN_BIT]) upper_same = 1'b0;
                if (masked && i < SIGN_BIT) stripped[i] = addr[top];
            end
        end
        if (addr[top] != addr[SIGN_BIT]) upper_same = 1'b0;

        fault  = masked ? (addr[SIGN_BIT] != addr[top]) : !upper_same;
        result = fault ? canon : stripped;
    end
endmodule

// File: rtl/addr_untag_unit.sv
module addr_untag_unit
    import addr_untag_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int NARROW_W = 48,
    parameter int WIDE_W   = 57
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              user_mask48,
    input  logic              user_mask57,
    input  logic              sup_mask_en,
    input  logic              paging5,
    input  logic              is_fetch,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_fault
);
    localparam int SIGN_BIT = ADDR_W - 1;

    mask_mode_e        mode_c;
    logic [ADDR_W-1:0] result_c;
    logic              fault_c;

    addr_mode_sel u_sel (
        .ptr_sup     (in_addr[SIGN_BIT]),
        .is_fetch    (is_fetch),
        .user_mask48 (user_mask48),
        .user_mask57 (user_mask57),
        .sup_mask_en (sup_mask_en),
        .paging5     (paging5),
        .mode        (mode_c)
    );

    addr_strip_check #(
        .ADDR_W   (ADDR_W),
        .NARROW_W (NARROW_W),
        .WIDE_W   (WIDE_W)
    ) u_strip (
        .addr    (in_addr),
        .mode    (mode_c),
        .paging5 (paging5),
        .result  (result_c),
        .fault   (fault_c)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_fault <= 1'b0;
            out_addr  <= '0;
        end else begin
            out_valid <= in_valid;
            out_fault <= in_valid & fault_c;
            if (in_valid) out_addr <= result_c;
        end
    end

    AST_VALID_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_fault)); // R2
    AST_FETCH_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_fetch) |=> (out_fault || out_addr == $past(in_addr))); // R9
    AST_SUP_OFF_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_fetch && in_addr[SIGN_BIT] && !sup_mask_en)
        |=> (out_fault || out_addr == $past(in_addr))); // R4
    AST_OUT_CANON: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((&out_addr[SIGN_BIT:WIDE_W-1]) || !(|out_addr[SIGN_BIT:WIDE_W-1]))); // R11
    AST_FAULT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> out_valid); // R2
endmodule

// File: tb/addr_untag_unit_tb.sv
module addr_untag_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_addr = '0;
    logic        user_mask48 = 1'b0, user_mask57 = 1'b0, sup_mask_en = 1'b0;
    logic        paging5 = 1'b0, is_fetch = 1'b0;
    logic        out_valid, out_fault;
    logic [63:0] out_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    addr_untag_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .user_mask48(user_mask48), .user_mask57(user_mask57),
        .sup_mask_en(sup_mask_en), .paging5(paging5), .is_fetch(is_fetch),
        .out_valid(out_valid), .out_addr(out_addr), .out_fault(out_fault)
    );

    localparam logic [63:0] ADDR_TAB [8] = '{
        64'h0000_1234_5678_9ABC, 64'hFFFF_8000_0000_1000,
        64'h7FFF_0000_0000_0040, 64'h8000_7FFF_FFFF_0000,
        64'h01FF_8000_0000_0008, 64'hFE00_0000_0000_0100,
        64'h3C00_F000_0000_0000, 64'hC2A5_5A5A_A5A5_5A5A
    };

    function automatic void model(input logic [63:0] a, input logic u48, input logic u57,
                                  input logic sup, input logic p5, input logic fe,
                                  output logic [63:0] ea, output logic ef);
        int w;
        bit m;
        logic [63:0] r;
        if (fe)         begin m = 0; w = 0; end
        else if (!a[63]) begin m = u57 | u48; w = u57 ? 57 : 48; end
        else            begin m = sup; w = p5 ? 57 : 48; end
        if (!m) w = p5 ? 57 : 48;
        r = a;
        if (m) begin
            ef = (a[63] != a[w-1]);
            for (int i = w; i < 63; i++) r[i] = a[w-1];
        end else begin
            ef = 0;
            for (int i = w - 1; i < 64; i++) if (a[i] != a[63]) ef = 1;
        end
        if (ef) for (int i = w; i < 64; i++) r[i] = a[w-1];
        ea = r;
    endfunction

    task automatic check(input string req, input logic [63:0] ea, input logic ef, input logic ev);
        checks++;
        if (out_addr !== ea || out_fault !== ef || out_valid !== ev) begin
            fails++;
            $display("FAIL %s: got v=%0b a=%h f=%0b, expected v=%0b a=%h f=%0b",
                     req, out_valid, out_addr, out_fault, ev, ea, ef);
        end
    endtask

    task automatic beat(input logic [63:0] a, input logic u48, input logic u57,
                        input logic sup, input logic p5, input logic fe);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a; user_mask48 = u48; user_mask57 = u57;
        sup_mask_en = sup; paging5 = p5; is_fetch = fe;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] ea;
        logic ef;
        repeat (3) @(negedge clk);
        check("R1 reset", 64'h0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 64'h0, 1'b0, 1'b0);

        // Sweep R3 R4 R5 R6 R7 R8 R9 R11: every control/paging/fetch combo, both bit-63 values
        for (int i = 0; i < 256; i++) begin
            logic [7:0] k;
            k = i[7:0];
            beat(ADDR_TAB[k[2:0]], k[3], k[4], k[5], k[6], k[7]);
            model(ADDR_TAB[k[2:0]], k[3], k[4], k[5], k[6], k[7], ea, ef);
            check("R3/R4/R7/R8 sweep", ea, ef, 1'b1);
        end

        // R5: user W48 untag
        beat(64'h7FFF_0000_1234_5678, 1, 0, 0, 0, 0);
        check("R5", 64'h0000_0000_1234_5678, 1'b0, 1'b1);
        // R6 / R3: user W57 wins over W48
        beat(64'h0AB0_8000_0000_0010, 1, 1, 0, 0, 0);
        check("R6", 64'h00B0_8000_0000_0010, 1'b0, 1'b1);
        // R7 / R11: supervisor W48 fault, canonical report
        beat(64'h8000_0000_0000_1000, 0, 0, 1, 0, 0);
        check("R7 R11", 64'h0000_0000_0000_1000, 1'b1, 1'b1);
        // R10: 5-level with user W48 clears bits 56:48
        beat(64'h01FF_0000_0000_0040, 1, 0, 0, 1, 0);
        check("R10", 64'h0000_0000_0000_0040, 1'b0, 1'b1);
        // R9: fetch ignores user W57, 5-level unmasked check faults
        beat(64'h0200_0000_0000_0000, 0, 1, 1, 1, 1);
        check("R9", 64'h0000_0000_0000_0000, 1'b1, 1'b1);
        // R8: canonical unmasked address passes through
        beat(64'hFFFF_8000_0000_0000, 0, 0, 0, 0, 0);
        check("R8", 64'hFFFF_8000_0000_0000, 1'b0, 1'b1);
        // R3: sup enable has no effect on a user pointer
        beat(64'h0F00_0000_0000_0000, 0, 0, 1, 0, 0);
        check("R3", 64'h0000_0000_0000_0000, 1'b1, 1'b1);
        // R4: user enables have no effect on a supervisor pointer
        beat(64'hFFFF_8000_0000_0000, 1, 1, 0, 1, 0);
        check("R4", 64'hFFFF_8000_0000_0000, 1'b0, 1'b1);
        // R2: idle cycle
        @(negedge clk);
        check("R2 idle", 64'hFFFF_8000_0000_0000, 1'b0, 1'b0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule